// File: doc/BRIEF.md
# Cascaded Priority Interrupt Controller

This block gathers fifteen device request lines into one interrupt request for a processor. Two identical eight-input stages do the work. The slave stage takes lines 8 to 15. Its combined request feeds master input 2, so line 2 has no pin of its own. The master stage takes lines 0, 1 and 3 to 7 together with that slave output.

Each stage samples its request levels into a pending register. It picks the most urgent pending line that is not masked, and it holds an in-service register for every line the processor has accepted. The interrupt output rises only when the winning request outranks everything already in service. The processor fetches an 8-bit vector number with a one-cycle acknowledge pulse. When its handler finishes, it writes end-of-interrupt commands through a small write-only configuration port. The same port sets the two vector bases and the per-line masks.

Top module: `irqCascadeTop`

## Requirements
- R1: After reset `intOut` and `vecValid` are low, every mask bit is 1, the master vector base is 08h and the slave vector base is 70h.
- R2: Configuration address 2 holds the master mask, where bit n masks line n and bit 2 masks the whole slave. Address 3 holds the slave mask, where bit i masks line 8+i. A masked line is never selected, and a lower-priority unmasked line is served in its place.
- R3: When `ackReq` is high at a clock edge, `vecValid` is high for exactly the following cycle. For a real request, `vecOut` is the upper five bits of the stage base followed by the three-bit line index within that stage.
- R4: Fixed priority from highest to lowest is line 0, line 1, lines 8 to 15 in ascending order, then lines 3 to 7 in ascending order.
- R5: `intOut` is high only when the selected request has no in-service bit of equal or higher priority in the master stage. A line that is still requesting while it is in service does not raise `intOut`.
- R6: Acknowledging a slave line sets both that line's slave in-service bit and master in-service bit 2. A higher master line is still blocked until an end-of-interrupt has been written to the slave stage and also to the master stage.
- R7: A request of higher priority than every line in service raises `intOut` and is acknowledged ahead of the lines already in service.
- R8: A write to address 4 clears the highest-priority master in-service bit, and a write to address 5 does the same in the slave stage. Lower in-service bits stay set.
- R9: Writes to address 0 set the master base and writes to address 1 set the slave base. Only data bits 7 to 3 are kept.
- R10: If no request is found at acknowledge time, the vector is the base of the stage concerned with index 7, and no in-service bit is set. This is the master base when the master has nothing pending, or the slave base when the master selected input 2 but the slave has nothing pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqLow | input | 2 | Request levels, lines 0 and 1 |
| irqMid | input | 5 | Request levels, lines 3 to 7 (range [7:3]) |
| irqSlv | input | 8 | Request levels, lines 8 to 15 (range [15:8]) |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 3 | Write address: 0/1 bases, 2/3 masks, 4/5 end-of-interrupt |
| cfgWdata | input | 8 | Write data |
| ackReq | input | 1 | One-cycle acknowledge pulse from the processor |
| intOut | output | 1 | Interrupt request to the processor |
| vecOut | output | 8 | Vector number, valid while vecValid is high |
| vecValid | output | 1 | Vector return strobe |

## Verification
Four properties are checked on every cycle. The acknowledge-to-vector timing must hold, line 0 in service must keep the output low, a new slave in-service bit must come with master bit 2, and no acknowledge may mark more than one master line. The full priority order, masking, nesting, the two-step end-of-interrupt for cascaded lines, reprogrammed bases and both spurious cases can only be shown by the bench's scenarios. The bench compares every returned vector against a queue of predicted values.

// File: rtl/irqCascadePkg.sv
package irqCascadePkg;
  localparam int LINES    = 8;
  localparam int IDXW     = $clog2(LINES);
  localparam int VECW     = 8;
  localparam int BASEW    = VECW - IDXW;
  localparam int CASC_IN  = 2;
  localparam int ADDRW    = 3;

  // configuration addresses
  localparam logic [ADDRW-1:0] A_MBASE = 3'd0;
  localparam logic [ADDRW-1:0] A_SBASE = 3'd1;
  localparam logic [ADDRW-1:0] A_MMASK = 3'd2;
  localparam logic [ADDRW-1:0] A_SMASK = 3'd3;
  localparam logic [ADDRW-1:0] A_MEOI  = 3'd4;
  localparam logic [ADDRW-1:0] A_SEOI  = 3'd5;

  typedef struct packed {
    logic            ldBase;
    logic            ldMask;
    logic            take;
    logic            eoi;
    logic [IDXW-1:0] takeIdx;
  } stageCmdT;
endpackage

// File: rtl/irqStageDp.sv
module irqStageDp
  import irqCascadePkg::*;
#(
  parameter logic [VECW-1:0] RESET_BASE = 8'h08
) (
  input  logic             clk,
  input  logic             rstN,
  input  stageCmdT         cmd,
  input  logic [VECW-1:0]  wdata,
  input  logic [LINES-1:0] reqLines,
  output logic             selValid,
  output logic [IDXW-1:0]  selIdx,
  output logic             intReq,
  output logic [BASEW-1:0] baseHi
);
  logic [LINES-1:0] pendQ, isrQ, maskQ;
  logic [BASEW-1:0] baseQ;
  logic [LINES-1:0] eligible, eoiMask, takeMask;
  logic             blocked;

  assign eligible = pendQ & ~maskQ;
  assign baseHi   = baseQ;
  assign takeMask = cmd.take ? (LINES'(1) << cmd.takeIdx) : '0;

  // lowest index wins
  always_comb begin
    selValid = 1'b0;
    selIdx   = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        selValid = 1'b1;
        selIdx   = IDXW'(i);
      end
    end
  end

  always_comb begin
    blocked = 1'b0;
    for (int i = 0; i < LINES; i++) begin
      if (isrQ[i] && (i <= int'(selIdx))) blocked = 1'b1;
    end
  end

  assign intReq = selValid && !blocked;

  // highest-priority in-service bit for end-of-interrupt
  always_comb begin
    eoiMask = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (isrQ[i]) eoiMask = LINES'(1) << i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= '0;
      isrQ  <= '0;
      maskQ <= '1;
      baseQ <= RESET_BASE[VECW-1:IDXW];
    end else begin
      pendQ <= reqLines & ~takeMask;
      isrQ  <= (isrQ & ~(cmd.eoi ? eoiMask : '0)) | takeMask;
      if (cmd.ldMask) maskQ <= wdata[LINES-1:0];
      if (cmd.ldBase) baseQ <= wdata[VECW-1:IDXW];
    end
  end
endmodule

// File: rtl/irqCascadeCtl.sv
module irqCascadeCtl
  import irqCascadePkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [ADDRW-1:0] cfgAddr,
  input  logic             ackReq,
  input  logic             mSelValid,
  input  logic [IDXW-1:0]  mSelIdx,
  input  logic             sSelValid,
  input  logic [IDXW-1:0]  sSelIdx,
  input  logic [BASEW-1:0] mBaseHi,
  input  logic [BASEW-1:0] sBaseHi,
  output stageCmdT         mCmd,
  output stageCmdT         sCmd,
  output logic [VECW-1:0]  vecOut,
  output logic             vecValid
);
  localparam logic [IDXW-1:0] CASC_IDX  = IDXW'(CASC_IN);
  localparam logic [IDXW-1:0] SPUR_IDX  = IDXW'(LINES - 1);

  logic [VECW-1:0] vecNext;

  always_comb begin
    mCmd = '0;
    sCmd = '0;
    mCmd.ldBase = cfgWe && (cfgAddr == A_MBASE);
    sCmd.ldBase = cfgWe && (cfgAddr == A_SBASE);
    mCmd.ldMask = cfgWe && (cfgAddr == A_MMASK);
    sCmd.ldMask = cfgWe && (cfgAddr == A_SMASK);
    mCmd.eoi    = cfgWe && (cfgAddr == A_MEOI);
    sCmd.eoi    = cfgWe && (cfgAddr == A_SEOI);
    vecNext     = {mBaseHi, SPUR_IDX};
    if (ackReq) begin
      if (mSelValid && (mSelIdx != CASC_IDX)) begin
        mCmd.take    = 1'b1;
        mCmd.takeIdx = mSelIdx;
        vecNext      = {mBaseHi, mSelIdx};
      end else if (mSelValid && sSelValid) begin
        mCmd.take    = 1'b1;
        mCmd.takeIdx = CASC_IDX;
        sCmd.take    = 1'b1;
        sCmd.takeIdx = sSelIdx;
        vecNext      = {sBaseHi, sSelIdx};
      end else if (mSelValid) begin
        vecNext      = {sBaseHi, SPUR_IDX};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecOut   <= '0;
      vecValid <= 1'b0;
    end else begin
      vecValid <= ackReq;
      if (ackReq) vecOut <= vecNext;
    end
  end
endmodule

// File: rtl/irqCascadeTop.sv
module irqCascadeTop
  import irqCascadePkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  irqLow,
  input  logic [7:3]  irqMid,
  input  logic [15:8] irqSlv,
  input  logic        cfgWe,
  input  logic [2:0]  cfgAddr,
  input  logic [7:0]  cfgWdata,
  input  logic        ackReq,
  output logic        intOut,
  output logic [7:0]  vecOut,
  output logic        vecValid
);
  stageCmdT         mCmd, sCmd;
  logic             mSelValid, sSelValid, sInt;
  logic [IDXW-1:0]  mSelIdx, sSelIdx;
  logic [BASEW-1:0] mBaseHi, sBaseHi;
  logic [LINES-1:0] mReq;

  assign mReq = {irqMid, sInt, irqLow};

  irqStageDp #(.RESET_BASE(8'h70)) uSlv (
    .clk(clk), .rstN(rstN), .cmd(sCmd), .wdata(cfgWdata), .reqLines(irqSlv),
    .selValid(sSelValid), .selIdx(sSelIdx), .intReq(sInt), .baseHi(sBaseHi)
  );

  irqStageDp #(.RESET_BASE(8'h08)) uMst (
    .clk(clk), .rstN(rstN), .cmd(mCmd), .wdata(cfgWdata), .reqLines(mReq),
    .selValid(mSelValid), .selIdx(mSelIdx), .intReq(intOut), .baseHi(mBaseHi)
  );

  irqCascadeCtl uCtl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .ackReq(ackReq),
    .mSelValid(mSelValid), .mSelIdx(mSelIdx), .sSelValid(sSelValid), .sSelIdx(sSelIdx),
    .mBaseHi(mBaseHi), .sBaseHi(sBaseHi), .mCmd(mCmd), .sCmd(sCmd),
    .vecOut(vecOut), .vecValid(vecValid)
  );
endmodule

// File: rtl/irqCascadeChk.sv
module irqCascadeChk (
  input logic       clk,
  input logic       rstN,
  input logic       ackReq,
  input logic       vecValid,
  input logic       intOut,
  input logic [7:0] mIsr,
  input logic [7:0] sIsr
);
  assert_ack_to_vec_R3: assert property (@(posedge clk) disable iff (!rstN)
    ackReq |=> vecValid);

  assert_vec_needs_ack_R3: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> $past(ackReq));

  // nothing outranks line 0, so line 0 in service silences the output
  assert_top_isr_blocks_R5: assert property (@(posedge clk) disable iff (!rstN)
    mIsr[0] |-> !intOut);

  assert_slave_marks_master_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((sIsr & ~$past(sIsr)) != 8'h00) |-> mIsr[2]);

  assert_single_take_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(mIsr & ~$past(mIsr)));
endmodule

bind irqCascadeTop irqCascadeChk uChk (
  .clk(clk), .rstN(rstN), .ackReq(ackReq), .vecValid(vecValid), .intOut(intOut),
  .mIsr(uMst.isrQ), .sIsr(uSlv.isrQ)
);

// File: tb/sim_irqCascadeTop.sv
module sim_irqCascadeTop;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] lines = '0;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [7:0]  cfgWdata = '0;
  logic        ackReq = 1'b0;
  logic        intOut, vecValid;
  logic [7:0]  vecOut;

  int nChecks = 0;
  int nFails  = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];

  always #2 clk = ~clk;

  irqCascadeTop u0 (
    .clk(clk), .rstN(rstN), .irqLow(lines[1:0]), .irqMid(lines[7:3]),
    .irqSlv(lines[15:8]), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .ackReq(ackReq), .intOut(intOut), .vecOut(vecOut), .vecValid(vecValid)
  );

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic doAck(input logic [7:0] expVec, input string tag);
    expQ.push_back(expVec);
    tagQ.push_back(tag);
    ackReq = 1'b1;
    @(negedge clk);
    ackReq = 1'b0;
  endtask

  task automatic checkInt(input logic expv, input string tag);
    nChecks++;
    if (intOut !== expv) begin
      nFails++;
      $display("FAIL %s intOut actual=%b expected=%b", tag, intOut, expv);
    end
  endtask

  // monitor: compare each returned vector with the scoreboard
  always @(negedge clk) begin
    if (rstN && vecValid) begin
      nChecks++;
      if (expQ.size() == 0) begin
        nFails++;
        $display("FAIL R3 unexpected vector actual=%h expected=none", vecOut);
      end else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (vecOut !== e) begin
          nFails++;
          $display("FAIL %s vector actual=%h expected=%h", t, vecOut, e);
        end
      end
    end
  end

  initial begin
    #400000;
    nChecks++; nFails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    checkInt(1'b0, "R1");
    nChecks++;
    if (vecValid !== 1'b0) begin
      nFails++; $display("FAIL R1 vecValid actual=%b expected=0", vecValid);
    end
    // R1/R2 all masked after reset
    lines[0] = 1'b1; settle(); checkInt(1'b0, "R1 reset mask");
    wr(3'd2, 8'h00); wr(3'd3, 8'h00); settle();
    checkInt(1'b1, "R3");
    doAck(8'h08, "R3 line0 default base");
    lines[0] = 1'b0; wr(3'd4, 8'h00); settle();
    checkInt(1'b0, "R8");

    // R4 priority order
    lines[1] = 1; lines[3] = 1; lines[9] = 1; lines[15] = 1; lines[7] = 1; settle();
    doAck(8'h09, "R4 line1"); settle();
    checkInt(1'b0, "R5 lower blocked");
    lines[1] = 0; wr(3'd4, 8'h00); settle();
    checkInt(1'b1, "R5 unblocked");
    doAck(8'h71, "R4 line9"); settle();
    lines[9] = 0; wr(3'd5, 8'h00); wr(3'd4, 8'h00); settle();
    doAck(8'h77, "R4 line15"); settle();
    lines[15] = 0; wr(3'd5, 8'h00); wr(3'd4, 8'h00); settle();
    doAck(8'h0B, "R4 line3"); settle();
    lines[3] = 0; wr(3'd4, 8'h00); settle();
    doAck(8'h0F, "R4 line7"); settle();
    lines[7] = 0; wr(3'd4, 8'h00); settle();
    checkInt(1'b0, "R8 all cleared");

    // R6 cascade needs two end-of-interrupt writes
    lines[9] = 1; settle();
    doAck(8'h71, "R6 slave ack");
    lines[9] = 0; lines[3] = 1; settle();
    checkInt(1'b0, "R6 master input 2 in service");
    wr(3'd5, 8'h00); settle();
    checkInt(1'b0, "R6 slave eoi alone");
    wr(3'd4, 8'h00); settle();
    checkInt(1'b1, "R6 both eoi");
    doAck(8'h0B, "R6 line3"); lines[3] = 0; wr(3'd4, 8'h00); settle();

    // R7 nesting, R8 eoi clears highest only
    lines[5] = 1; settle();
    doAck(8'h0D, "R7 line5"); settle();
    checkInt(1'b0, "R5 equal priority in service");
    lines[0] = 1; settle();
    checkInt(1'b1, "R7 nested");
    doAck(8'h08, "R7 line0 nested");
    lines[0] = 0; wr(3'd4, 8'h00); settle();
    checkInt(1'b0, "R8 line5 still in service");
    wr(3'd4, 8'h00); settle();
    checkInt(1'b1, "R8 second eoi");
    doAck(8'h0D, "R8 line5 again"); lines[5] = 0; wr(3'd4, 8'h00); settle();

    // R2 per-line mask
    wr(3'd2, 8'h08); lines[3] = 1; settle();
    checkInt(1'b0, "R2 line3 masked");
    lines[4] = 1; settle();
    doAck(8'h0C, "R2 line4 past masked line3");
    lines[4] = 0; wr(3'd4, 8'h00); lines[3] = 0; wr(3'd2, 8'h00); settle();

    // R9 base programming
    wr(3'd0, 8'h23); wr(3'd1, 8'h4F);
    lines[1] = 1; settle();
    doAck(8'h21, "R9 master base");
    lines[1] = 0; wr(3'd4, 8'h00);
    lines[12] = 1; settle();
    doAck(8'h4C, "R9 slave base");
    lines[12] = 0; wr(3'd5, 8'h00); wr(3'd4, 8'h00);
    wr(3'd0, 8'h08); wr(3'd1, 8'h70); settle();

    // R10 spurious vectors
    lines[4] = 1; settle(); lines[4] = 0; settle();
    doAck(8'h0F, "R10 master spurious"); settle();
    lines[10] = 1; settle();
    lines[10] = 0; @(negedge clk);
    doAck(8'h77, "R10 slave spurious"); settle();
    lines[3] = 1; settle();
    checkInt(1'b1, "R10 nothing left in service");
    doAck(8'h0B, "R10 line3"); lines[3] = 0; wr(3'd4, 8'h00); settle();

    nChecks++;
    if (expQ.size() != 0) begin
      nFails++;
      $display("FAIL R3 vectors missing actual=%0d expected=0", expQ.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule